// File: doc/BRIEF.md
# Station Name Gate for a Shared Half-Duplex Line

This block sits between a UART receiver and a line transceiver on a node that shares one half-duplex serial line with many other nodes. While idle it never drives the line. It watches every received byte for the node's own station name, which is a programmable ASCII string of one to eight characters. The driver stays disabled until that name turns up in the byte stream, so any number of nodes can listen on the same wire without fighting over it.

When the last character of the name arrives, the block turns the transceiver towards the line and asks the transmitter to send a single acknowledgment character. It then holds the line for the exchange that follows. The session closes on any of three events: a release pulse, a configurable end-of-session character, or a programmable stretch of clock cycles with no received byte. The driver is not released straight away. It stays enabled until the transmitter reports that its last stop bit has left, and only then does the block return to silent scanning.

Top module: `drop_gate`

## Requirements
- R1: After reset `drv_en` is 0 and `tx_req` is 0.
- R2: `drv_en` = 1 means transmit and 0 means receive. `drv_en` rises on the clock edge that accepts the final name character, and `tx_req` rises on that same edge with `tx_data` equal to `ack_char`.
- R3: The name is `name_len` characters long (1 to 8). Character k, where k = 0 is the first character sent, sits at `name_cfg[8k+7:8k]`. A name of length 1 and a name of length 8 both match.
- R4: If a byte does not match the expected character, scanning starts again. If that byte equals character 0, it counts as the first matched character. So name "ABC" matches in the stream "ABABC", and name "BOB" does not match in "BXOB".
- R5: `tx_req` stays high, with `tx_data` stable, until a cycle in which `tx_ack` is 1, and then drops. A session requests exactly one byte. Sending the name again during a session raises no new request.
- R6: A one-cycle pulse on `sess_end` during a session closes it.
- R7: When `eos_en` = 1, receiving `eos_char` during a session closes it. When `eos_en` = 0, that character has no effect.
- R8: When `tmo_limit` is non-zero, a session closes once no byte has arrived for more than `tmo_limit` cycles. Each received byte restarts this count. When `tmo_limit` = 0, there is no timeout.
- R9: After a session closes, `drv_en` stays 1 until `tx_idle` is 1. It then falls on the next clock edge.
- R10: Bytes received during a session are not scanned for the name. Scanning starts again from the first character once the block is back in the silent state.
- R11: A value on `rx_data` has no effect unless `rx_valid` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking `rx_data` as a new byte |
| name_cfg | input | 64 | Station name; character k at bits [8k+7:8k] |
| name_len | input | 4 | Number of name characters, 1 to 8 |
| ack_char | input | 8 | Acknowledgment character sent after a match |
| eos_char | input | 8 | Character that closes a session |
| eos_en | input | 1 | Enables closing on `eos_char` |
| sess_end | input | 1 | Pulse that closes the session |
| tmo_limit | input | 16 | Idle cycles allowed in a session; 0 disables the timeout |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_req | output | 1 | Request to transmit `tx_data` |
| tx_ack | input | 1 | Transmitter accepted `tx_data` |
| tx_idle | input | 1 | Transmitter has finished its last stop bit |
| drv_en | output | 1 | Transceiver direction: 1 transmit, 0 receive |

## Verification
The bench builds the block with its default parameters: an eight-character name buffer, a 16-bit idle counter and the timeout logic present. With these values it can drive names of length 1, 3 and 8, which covers the shortest name, a typical name and a name that fills every buffer slot. It sets the idle limit to 20 cycles, which is short enough to reach both a timeout and a restart of the count within a few dozen cycles, and it also runs with the limit at 0. Holding `tx_idle` low keeps the drain state open for as long as needed, so the bench can watch the driver stay enabled after a session closes.

// File: rtl/drop_gate_pkg.sv
package drop_gate_pkg;

   typedef enum logic [1:0] {
      GS_SILENT = 2'd0,
      GS_ACK    = 2'd1,
      GS_OPEN   = 2'd2,
      GS_DRAIN  = 2'd3
   } gate_st_e;

endpackage

// File: rtl/drop_gate_scan.sv
module drop_gate_scan #(
   parameter int NAME_MAX = 8,
   parameter int BYTE_W   = 8,
   parameter int PW       = $clog2(NAME_MAX + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scan_en,
   input  logic [BYTE_W-1:0]          byte_i,
   input  logic                       byte_vld,
   input  logic [NAME_MAX*BYTE_W-1:0] name_i,
   input  logic [PW-1:0]              len_i,
   output logic                       hit_o
);

   localparam int IW = (NAME_MAX > 1) ? $clog2(NAME_MAX) : 1;

   logic [NAME_MAX-1:0] eq;
   logic [PW-1:0]       pos_q, pos_d, len_eff;

   // compare the incoming byte against every name slot in parallel
   for (genvar g = 0; g < NAME_MAX; g++) begin : g_cmp
      assign eq[g] = (name_i[g*BYTE_W +: BYTE_W] == byte_i);
   end

   // lengths of 0 count as 1, and lengths above the buffer size are cut to NAME_MAX
   always_comb begin
      if (len_i == '0)                 len_eff = PW'(1);
      else if (len_i > PW'(NAME_MAX))  len_eff = PW'(NAME_MAX);
      else                             len_eff = len_i;
   end

   always_comb begin
      pos_d = pos_q;
      hit_o = 1'b0;
      if (!scan_en) begin
         pos_d = '0;
      end else if (byte_vld) begin
         if (eq[pos_q[IW-1:0]]) begin
            if (pos_q + PW'(1) == len_eff) begin
               hit_o = 1'b1;
               pos_d = '0;
            end else begin
               pos_d = pos_q + PW'(1);
            end
         end else if (eq[0]) begin
            // the byte that broke the match may start a fresh one
            if (len_eff == PW'(1)) begin
               hit_o = 1'b1;
               pos_d = '0;
            end else begin
               pos_d = PW'(1);
            end
         end else begin
            pos_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= '0;
      else        pos_q <= pos_d;
   end

   assert_pos_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q < PW'(NAME_MAX));

   assert_hit_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (byte_vld && scan_en));

   assert_silent_pos_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> (pos_q == '0));

endmodule

// File: rtl/drop_gate_idle.sv
module drop_gate_idle #(
   parameter int TMO_W   = 16,
   parameter bit USE_TMO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             byte_vld,
   input  logic [TMO_W-1:0] limit,
   output logic             expire_o
);

   if (USE_TMO) begin : g_tmo
      logic [TMO_W-1:0] cnt_q;

      assign expire_o = run && (limit != '0) && (cnt_q >= limit);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 cnt_q <= '0;
         else if (!run || byte_vld)  cnt_q <= '0;
         else if (!expire_o)         cnt_q <= cnt_q + TMO_W'(1);
      end

      assert_tmo_zero_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
         expire_o |-> (limit != '0));

      assert_tmo_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (run && byte_vld) |=> !expire_o);
   end else begin : g_no_tmo
      logic unused_in;
      assign unused_in = ^{run, byte_vld, limit, clk, rst_n};
      assign expire_o  = 1'b0;
   end

endmodule

// File: rtl/drop_gate.sv
module drop_gate
   import drop_gate_pkg::*;
#(
   parameter int NAME_MAX = 8,
   parameter int BYTE_W   = 8,
   parameter int TMO_W    = 16,
   parameter bit USE_TMO  = 1'b1,
   parameter int PW       = $clog2(NAME_MAX + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [BYTE_W-1:0]          rx_data,
   input  logic                       rx_valid,
   input  logic [NAME_MAX*BYTE_W-1:0] name_cfg,
   input  logic [PW-1:0]              name_len,
   input  logic [BYTE_W-1:0]          ack_char,
   input  logic [BYTE_W-1:0]          eos_char,
   input  logic                       eos_en,
   input  logic                       sess_end,
   input  logic [TMO_W-1:0]           tmo_limit,
   output logic [BYTE_W-1:0]          tx_data,
   output logic                       tx_req,
   input  logic                       tx_ack,
   input  logic                       tx_idle,
   output logic                       drv_en
);

   if (NAME_MAX < 1 || NAME_MAX > 32) begin : g_bad_name
      initial $fatal(1, "drop_gate: NAME_MAX out of range");
   end
   if (BYTE_W < 5 || TMO_W < 2) begin : g_bad_width
      initial $fatal(1, "drop_gate: BYTE_W or TMO_W too small");
   end

   gate_st_e          st_q, st_d;
   logic              name_hit, idle_exp, eos_hit, close_ev;
   logic [BYTE_W-1:0] ack_q;
   logic              dir_q;

   drop_gate_scan #(.NAME_MAX(NAME_MAX), .BYTE_W(BYTE_W), .PW(PW)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .scan_en  (st_q == GS_SILENT),
      .byte_i   (rx_data),
      .byte_vld (rx_valid),
      .name_i   (name_cfg),
      .len_i    (name_len),
      .hit_o    (name_hit)
   );

   drop_gate_idle #(.TMO_W(TMO_W), .USE_TMO(USE_TMO)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (st_q == GS_OPEN),
      .byte_vld (rx_valid),
      .limit    (tmo_limit),
      .expire_o (idle_exp)
   );

   assign eos_hit  = eos_en && rx_valid && (rx_data == eos_char);
   assign close_ev = sess_end || eos_hit || idle_exp;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         GS_SILENT: if (name_hit) st_d = GS_ACK;
         GS_ACK:    if (tx_ack)   st_d = GS_OPEN;
         GS_OPEN:   if (close_ev) st_d = GS_DRAIN;
         GS_DRAIN:  if (tx_idle)  st_d = GS_SILENT;
         default:                 st_d = GS_SILENT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= GS_SILENT;
         dir_q <= 1'b0;
         ack_q <= '0;
      end else begin
         st_q  <= st_d;
         dir_q <= (st_d != GS_SILENT);
         if (st_q == GS_SILENT && name_hit) ack_q <= ack_char;
      end
   end

   assign drv_en  = dir_q;
   assign tx_req  = (st_q == GS_ACK);
   assign tx_data = ack_q;

   assert_req_needs_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> drv_en);

   assert_dir_rise_on_name_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en) |-> $past(name_hit));

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_ack) |=> tx_req);

   assert_req_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_ack) |=> $stable(tx_data));

   assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && tx_ack) |=> !tx_req);

   assert_dir_fall_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_en) |-> $past(tx_idle));

endmodule

// File: tb/sim_drop_gate.sv
`timescale 1ns/1ps
module sim_drop_gate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0;
   logic [63:0] name_cfg = '0;
   logic [3:0]  name_len = 4'd1;
   logic [7:0]  ack_char = 8'h06;
   logic [7:0]  eos_char = 8'h23;
   logic        eos_en = 1'b0;
   logic        sess_end = 1'b0;
   logic [15:0] tmo_limit = '0;
   logic [7:0]  tx_data;
   logic        tx_req;
   logic        tx_ack = 1'b0;
   logic        tx_idle = 1'b1;
   logic        drv_en;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   drop_gate u0 (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
      .name_cfg(name_cfg), .name_len(name_len), .ack_char(ack_char),
      .eos_char(eos_char), .eos_en(eos_en), .sess_end(sess_end),
      .tmo_limit(tmo_limit), .tx_data(tx_data), .tx_req(tx_req),
      .tx_ack(tx_ack), .tx_idle(tx_idle), .drv_en(drv_en)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_name(string s);
      name_cfg = '0;
      for (int i = 0; i < s.len(); i++) name_cfg[8*i +: 8] = s[i];
      name_len = 4'(s.len());
   endtask

   task automatic send_str(string s);
      for (int i = 0; i < s.len(); i++) begin
         @(negedge clk);
         rx_data  = s[i];
         rx_valid = 1'b1;
      end
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic give_ack();
      @(negedge clk);
      tx_ack = 1'b1;
      @(negedge clk);
      tx_ack = 1'b0;
   endtask

   task automatic close_by_release();
      @(negedge clk);
      sess_end = 1'b1;
      @(negedge clk);
      sess_end = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", "drv_en after reset", 32'(drv_en), 0);
      chk("R1", "tx_req after reset", 32'(tx_req), 0);
   endtask

   task automatic t_basic();
      set_name("BOB");
      ack_char = 8'h06;
      send_str("BO");
      chk("R2", "drv_en before last char", 32'(drv_en), 0);
      send_str("B");
      chk("R2", "drv_en after name", 32'(drv_en), 1);
      chk("R2", "tx_req after name", 32'(tx_req), 1);
      chk("R2", "tx_data is ack", 32'(tx_data), 32'h06);
      wait_n(4);
      chk("R5", "tx_req held without tx_ack", 32'(tx_req), 1);
      give_ack();
      chk("R5", "tx_req after tx_ack", 32'(tx_req), 0);
      chk("R6", "drv_en in session", 32'(drv_en), 1);
      send_str("BOB");
      chk("R5", "no second request", 32'(tx_req), 0);
      @(negedge clk);
      sess_end = 1'b1;
      @(negedge clk);
      sess_end = 1'b0;
      chk("R9", "drv_en one cycle after close", 32'(drv_en), 1);
      @(negedge clk);
      chk("R6", "drv_en after release", 32'(drv_en), 0);
   endtask

   task automatic t_overlap();
      set_name("ABC");
      send_str("ABAB");
      chk("R4", "ABAB not a match", 32'(drv_en), 0);
      send_str("C");
      chk("R4", "ABABC matches", 32'(drv_en), 1);
      give_ack();
      close_by_release();
      set_name("BOB");
      send_str("BXOB");
      chk("R4", "BXOB not a match", 32'(drv_en), 0);
      send_str("OB");
      chk("R4", "restart on B then OB matches", 32'(drv_en), 1);
      give_ack();
      close_by_release();
   endtask

   task automatic t_lengths();
      set_name("Q");
      send_str("xyQ");
      chk("R3", "length 1 match", 32'(drv_en), 1);
      give_ack();
      close_by_release();
      chk("R3", "length 1 closed", 32'(drv_en), 0);
      set_name("STATION8");
      send_str("STATION");
      chk("R3", "7 of 8 chars", 32'(drv_en), 0);
      send_str("8");
      chk("R3", "length 8 match", 32'(drv_en), 1);
      give_ack();
      close_by_release();
   endtask

   task automatic t_valid_low();
      set_name("BOB");
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         rx_data = (i == 1) ? 8'h4F : 8'h42;
      end
      wait_n(2);
      chk("R11", "bytes without valid ignored", 32'(drv_en), 0);
   endtask

   task automatic t_eos();
      set_name("BOB");
      eos_en = 1'b0;
      send_str("BOB");
      give_ack();
      send_str("#");
      wait_n(3);
      chk("R7", "end char ignored when disabled", 32'(drv_en), 1);
      eos_en = 1'b1;
      send_str("#");
      @(negedge clk);
      chk("R7", "end char closes session", 32'(drv_en), 0);
      eos_en = 1'b0;
   endtask

   task automatic t_timeout();
      set_name("BOB");
      tmo_limit = 16'd0;
      send_str("BOB");
      give_ack();
      wait_n(100);
      chk("R8", "limit 0 never times out", 32'(drv_en), 1);
      close_by_release();
      tmo_limit = 16'd20;
      send_str("BOB");
      give_ack();
      wait_n(10);
      chk("R8", "still open mid-window", 32'(drv_en), 1);
      send_str("z");
      wait_n(15);
      chk("R8", "byte restarted idle count", 32'(drv_en), 1);
      wait_n(12);
      chk("R8", "idle timeout closed session", 32'(drv_en), 0);
      tmo_limit = 16'd0;
   endtask

   task automatic t_drain();
      set_name("BOB");
      send_str("BOB");
      give_ack();
      tx_idle = 1'b0;
      @(negedge clk);
      sess_end = 1'b1;
      @(negedge clk);
      sess_end = 1'b0;
      wait_n(10);
      chk("R9", "drv_en held while tx busy", 32'(drv_en), 1);
      tx_idle = 1'b1;
      @(negedge clk);
      chk("R9", "drv_en drops after tx_idle", 32'(drv_en), 0);
   endtask

   task automatic t_rescan();
      set_name("BOB");
      send_str("BOB");
      give_ack();
      send_str("BO");
      close_by_release();
      send_str("B");
      chk("R10", "partial from session not kept", 32'(drv_en), 0);
      send_str("OB");
      chk("R10", "fresh scan matches", 32'(drv_en), 1);
      give_ack();
      close_by_release();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      wait_n(3);
      t_reset();
      rst_n = 1'b1;
      wait_n(2);
      t_reset();
      t_basic();
      t_overlap();
      t_lengths();
      t_valid_low();
      t_eos();
      t_timeout();
      t_drain();
      t_rescan();
      wait_n(2);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule